// File: doc/BRIEF.md
# Two-Wire Clock Configuration Register Slave

This block is the configuration port of a clock generator. A board controller reaches it over a two-wire serial bus: it writes a run of configuration bytes, or reads them back for verification. The slave holds seven 8-bit registers. Their contents are driven out as one flat parallel vector, and the synthesizer, spread and output-gating logic nearby decodes that vector. The bus lines are oversampled by a faster system clock. Each line passes through a two-flop synchronizer, and start, stop and clock edges are found by comparing the synchronized level with the level one cycle earlier. The slave never stretches the clock and has no arbitration logic.

Access is always sequential and always begins at register 0. A write frame carries the address byte, then a command byte and a byte-count byte, then the data bytes. The slave acknowledges the command and byte-count bytes but does not use their values. Each data byte goes into the next register in turn. A read frame returns register 0, register 1 and so on, starting right after the address acknowledge.

The control machine has eight states:
- IDLE: the bus is free.
- ADDR: the address byte is being shifted in.
- ACK_ADDR: the slave drives the address acknowledge.
- RX: a write byte is being shifted in.
- ACK_RX: the slave drives a write-byte acknowledge.
- TX: a read byte is being shifted out.
- TX_MACK: the master's acknowledge bit is sampled.
- IGNORE: the slave stays silent until the next start.

The transitions are:
- start, from any state, goes to ADDR.
- stop, from any state, goes to IDLE.
- ADDR goes to ACK_ADDR when the address matches, and to IGNORE when it does not.
- ACK_ADDR goes to RX or to TX, according to the R/W bit.
- RX goes to ACK_RX, and ACK_RX goes back to RX.
- TX goes to TX_MACK.
- TX_MACK goes to TX when the master acknowledges, and to IGNORE when it does not.

Top module: `cfg_twi_slave`

## Requirements
- R1: After reset the registers hold these values: 0x00 in register 0, 0xFF in registers 1, 2 and 3, 0x0F in register 4, 0x13 in register 5 and 0x00 in register 6. SDA is not driven.
- R2: A start condition restarts address reception from any state. This holds even in the middle of a byte, and no register is written by the partial byte. A stop condition returns the slave to idle with SDA released.
- R3: The address byte is sent MSB first. Its upper seven bits must equal 1101001 and bit 0 is the R/W bit (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock.
- R4: With any other address the slave gives no acknowledge and changes no register. It ignores every following byte until the next start.
- R5: In a write, the two bytes after the address are acknowledged. Their values are never stored.
- R6: In a write, each following byte is received MSB first. It is stored into register 0, then register 1 and so on, and each one is acknowledged.
- R7: In a write, bytes beyond register 6 are acknowledged and discarded.
- R8: In a read, the slave sends register 0, then register 1 and so on, MSB first. Each byte starts right after the preceding acknowledge, and SDA is released during the master's acknowledge bit.
- R9: In a read, bytes requested beyond register 6 read as 0xFF.
- R10: When the master does not acknowledge a read byte, the slave stops driving SDA until the next start or stop.
- R11: Register k appears on cfg_o bits [8k+7:8k]. In register 0 the fields are placed as follows:
  - bit 7: spread amplitude
  - bits 6:4: software frequency code
  - bit 3: software/hardware select
  - bit 2: down/center spread
  - bit 1: spread enable
  - bit 0: tri-state all outputs
- R12: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 56 | Register contents, register k at bits [8k+7:8k] |

## Verification
The checker evaluates the following on every cycle:
- SDA drive begins only while SCL is low.
- A start leads to address reception, and a stop leads to idle with SDA released.
- Register writes happen only in write frames and only to existing registers.
- The register vector holds its value whenever no write strobe fires.
- The ignore state persists until a bus condition ends it.

Address matching, the dropping of the two dummy bytes, the register order, the 0xFF padding past the last register, the silence after a master NACK, and the effect of a repeated start in mid-byte all depend on whole bus frames. Only the bench's directed scenarios can show those.

// File: rtl/cfg_twi_pkg.sv
package cfg_twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX,
        ST_ACK_RX,
        ST_TX,
        ST_TX_MACK,
        ST_IGNORE
    } twi_state_t;

    // Number of dummy bytes that precede write data.
    localparam int unsigned DUMMY_BYTES = 2;

    // Power-up content of each configuration register; reserved bits read as zero.
    function automatic logic [7:0] por_value(int unsigned idx);
        case (idx)
            0:       return 8'h00;
            1, 2, 3: return 8'hFF;
            4:       return 8'h0F;
            5:       return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] now;
    logic [1:0] old;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-1:0], raw[g]};
        end
        assign now[g] = sh[STAGES-1];
        assign old[g] = sh[STAGES];
    end

    assign scl_s     = now[1];
    assign sda_s     = now[0];
    assign scl_rise  = now[1] & ~old[1];
    assign scl_fall  = ~now[1] & old[1];
    assign start_det = now[1] & old[1] & old[0] & ~now[0];
    assign stop_det  = now[1] & old[1] & ~old[0] & now[0];
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_twi_pkg::*;
#(
    parameter int NREG = 7,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_flat
);
    logic [7:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   regs[i] <= por_value(i);
            else if (wr_en && wr_idx == IDXW'(i))         regs[i] <= wr_data;
        end
        assign cfg_flat[i*8 +: 8] = regs[i];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IDXW'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/cfg_twi_slave.sv
module cfg_twi_slave
    import cfg_twi_pkg::*;
#(
    parameter int         NREG     = 7,
    parameter logic [6:0] SLV_ADDR = 7'b1101001,
    parameter int         SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int IDXW = $clog2(NREG + 1);
    localparam logic [IDXW-1:0] IDX_END = IDXW'(NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_bus_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_state_t      state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [7:0]      txsh;
    logic [IDXW-1:0] idx;
    logic [1:0]      dcnt;
    logic            rw;
    logic            byte_done;
    logic            wr_en;
    logic [7:0]      rd_data;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign wr_en = (state == ST_RX) && byte_done && !start_det && !stop_det
                   && (dcnt == 2'(DUMMY_BYTES)) && (idx != IDX_END);

    cfg_regfile #(.NREG(NREG), .IDXW(IDXW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(shreg),
        .rd_idx(idx), .rd_data(rd_data), .cfg_flat(cfg_o)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '1;
            idx    <= '0;
            dcnt   <= '0;
            rw     <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            dcnt   <= '0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == SLV_ADDR) begin
                                state <= ST_ACK_ADDR;
                                rw    <= shreg[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            state <= ST_ACK_RX;
                            if (dcnt != 2'(DUMMY_BYTES)) dcnt <= dcnt + 2'd1;
                            else if (idx != IDX_END)      idx  <= idx + 1'b1;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        if (rw) begin
                            state <= ST_TX;
                            txsh  <= rd_data;
                            if (idx != IDX_END) idx <= idx + 1'b1;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (scl_fall) state <= ST_RX;
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            bitcnt <= '0;
                            state  <= ST_TX_MACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            txsh   <= {txsh[6:0], 1'b1};
                        end
                    end
                end
                ST_TX_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            state <= ST_IGNORE;
                        end else begin
                            txsh <= rd_data;
                            if (idx != IDX_END) idx <= idx + 1'b1;
                        end
                    end else if (scl_fall) begin
                        state <= ST_TX;
                    end
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ACK_ADDR, ST_ACK_RX: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~txsh[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_twi_slave_chk.sv
module cfg_twi_slave_chk
    import cfg_twi_pkg::*;
#(
    parameter int NREG = 7,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input twi_state_t        state,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [IDXW-1:0]   wr_idx,
    input logic              rw,
    input logic [NREG*8-1:0] cfg_o
);
    p_oe_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR);

    p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDXW'(NREG)));

    p_write_only_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rw);

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    p_ignore_persists_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && !start_det && !stop_det) |=> state == ST_IGNORE);
endmodule

bind cfg_twi_slave cfg_twi_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(idx), .rw(rw), .cfg_o(cfg_o)
);

// File: tb/cfg_twi_slave_tb.sv
module cfg_twi_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 7;
    localparam logic [7:0] AW = 8'hD2;
    localparam logic [7:0] AR = 8'hD3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg;

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_twi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_o(cfg)
    );

    int checks = 0;
    int errors = 0;
    int r12_viol = 0;
    logic oe_q = 1'b0;
    logic [7:0] exp_r [NREG];

    always @(posedge clk) begin
        if (sda_oe && !oe_q && scl) r12_viol++;
        oe_q = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] exp_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_r[i];
        return v;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        acked = !sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
        end
        sda_m = !give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        exp_r[0] = 8'h00; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF; exp_r[3] = 8'hFF;
        exp_r[4] = 8'h0F; exp_r[5] = 8'h13; exp_r[6] = 8'h00;
        chk(cfg == exp_vec(), "R1", "reset register values", 64'(cfg), 64'(exp_vec()));
        chk(sda_oe == 1'b0, "R1", "SDA released after reset", 64'(sda_oe), 64'd0);
        chk(cfg[7:0] == 8'h00 && cfg[15:8] == 8'hFF && cfg[47:40] == 8'h13,
            "R11", "register placement on cfg_o", 64'(cfg), 64'(exp_vec()));
    endtask

    task automatic t_write_basic();
        bit a;
        bus_start();
        send_byte(AW, a);   chk(a, "R3", "address ack on write", 64'(a), 64'd1);
        send_byte(8'hA5, a); chk(a, "R5", "command byte ack", 64'(a), 64'd1);
        send_byte(8'h5A, a); chk(a, "R5", "count byte ack", 64'(a), 64'd1);
        send_byte(8'h81, a); chk(a, "R6", "data0 ack", 64'(a), 64'd1);
        send_byte(8'h22, a); chk(a, "R6", "data1 ack", 64'(a), 64'd1);
        send_byte(8'h33, a); chk(a, "R6", "data2 ack", 64'(a), 64'd1);
        bus_stop();
        exp_r[0] = 8'h81; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
        chk(cfg == exp_vec(), "R6", "regs after write, dummies not stored (R5)",
            64'(cfg), 64'(exp_vec()));
        chk(sda_oe == 1'b0, "R2", "SDA released after stop", 64'(sda_oe), 64'd0);
    endtask

    task automatic t_bad_addr();
        bit a;
        int acks = 0;
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R4", "no ack on foreign address", 64'(a), 64'd0);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h00, a);
            if (a) acks++;
        end
        bus_stop();
        chk(acks == 0, "R4", "following bytes not acked", 64'(acks), 64'd0);
        chk(cfg == exp_vec(), "R4", "regs unchanged", 64'(cfg), 64'(exp_vec()));
    endtask

    task automatic t_write_overflow();
        bit a;
        int acks = 0;
        bus_start();
        send_byte(AW, a); send_byte(8'h00, a); send_byte(8'h00, a);
        for (int i = 0; i < 9; i++) begin
            send_byte(8'(8'h10 + i), a);
            if (a) acks++;
            if (i < NREG) exp_r[i] = 8'(8'h10 + i);
        end
        bus_stop();
        chk(acks == 9, "R7", "all nine data bytes acked", 64'(acks), 64'd9);
        chk(cfg == exp_vec(), "R7", "extra bytes discarded", 64'(cfg), 64'(exp_vec()));
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(AR, a); chk(a, "R3", "address ack on read", 64'(a), 64'd1);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(1'b1, b);
            chk(b == exp_r[i], "R8", $sformatf("read reg %0d", i), 64'(b), 64'(exp_r[i]));
        end
        recv_byte(1'b1, b); chk(b == 8'hFF, "R9", "read past end 1", 64'(b), 64'hFF);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R9", "read past end 2", 64'(b), 64'hFF);
        bus_stop();
    endtask

    task automatic t_nack();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b0, b); chk(b == exp_r[0], "R8", "first read byte", 64'(b), 64'(exp_r[0]));
        recv_byte(1'b0, b); chk(b == 8'hFF, "R10", "no drive after master NACK", 64'(b), 64'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(AW, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h44, a); exp_r[0] = 8'h44;
        send_bits(8'h99, 4);
        bus_start();
        chk(cfg == exp_vec(), "R2", "partial byte not stored", 64'(cfg), 64'(exp_vec()));
        send_byte(AR, a); chk(a, "R2", "address ack after repeated start", 64'(a), 64'd1);
        recv_byte(1'b0, b); chk(b == 8'h44, "R2", "read after repeated start", 64'(b), 64'h44);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_basic();
        t_bad_addr();
        t_write_overflow();
        t_read();
        t_nack();
        t_restart();
        chk(r12_viol == 0, "R12", "drive begun while SCL high", 64'(r12_viol), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule